// File: doc/BRIEF.md
# Pipeline Forwarding and Load-Use Interlock Unit

This unit holds the hazard control of a five-stage in-order integer pipeline whose stages are fetch, decode, execute, memory and write-back. Each cycle it takes the register fields of the instruction sitting in decode: two source registers, a destination register, a write-enable flag and a load flag. It follows those fields down three small control registers for the execute, memory and write-back stages. From them it derives two operand-select codes for the execute-stage input multiplexers, and a stall that both freezes the program counter and the decode register and turns the next execute entry into a no-op.

A result can reach a consumer from the memory stage or from the write-back stage. When both hold the same register, the younger producer (the one in memory) wins. A consumer three slots behind a producer is not forwarded, because the register file is written in the first half of a cycle and read in the second. The only case that forwarding cannot cover is a consumer right behind a load. That case costs one stall cycle, after which the load data comes from the write-back stage. Write-after-read and write-after-write checks are not needed, since every instruction reads in decode and writes in write-back.

The surrounding pipeline must hold the decode inputs unchanged during a stall cycle. The datapath, the arithmetic unit and the memories are not part of the block.

Top module: `pipe_hazard_unit`

## Requirements
- R1: After a clock edge with `rst_n` low, all three stage registers are empty. `stall` and `bubble` are 0, and `fwd_a` and `fwd_b` are 2'b00.
- R2: An execute operand whose source equals the destination of the memory-stage instruction selects 2'b10 (memory-stage result), provided that instruction writes and its destination is not register 0.
- R3: When R2 does not apply and the source equals the destination of a writing write-back-stage instruction with a nonzero destination, the select is 2'b01 (write-back result).
- R4: When both the memory-stage and the write-back-stage instructions write the matching register, the select is 2'b10 (youngest producer wins).
- R5: In all other cases the select is 2'b00 (register-file value). This includes a producer three instructions ahead, which has already left write-back.
- R6: A destination of register 0 is never forwarded and never causes a stall.
- R7: A producer whose write-enable is low is never forwarded and never causes a stall.
- R8: `stall` and `bubble` are 1 in the same cycle exactly when the execute-stage instruction is a writing load with a nonzero destination equal to either decode source.
- R9: Load data reaches its dependent through select 2'b01. This holds both after a load-use stall and when one instruction separates the load from its consumer.
- R10: A stall lasts one cycle. The no-op it places in execute never forwards and never stalls.
- R11: `fwd_b` follows the same rules for the second source. This select also steers the store-data operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs1 | input | 5 | First source register of the decode instruction |
| id_rs2 | input | 5 | Second source register (also store data) of the decode instruction |
| id_rd | input | 5 | Destination register of the decode instruction |
| id_wen | input | 1 | Decode instruction writes its destination |
| id_load | input | 1 | Decode instruction is a load |
| stall | output | 1 | Freeze program counter and decode register |
| bubble | output | 1 | Load a no-op into the execute stage at the next edge |
| fwd_a | output | 2 | Select for execute operand A: 00 register file, 01 write-back, 10 memory stage |
| fwd_b | output | 2 | Select for execute operand B and store data, same coding |

## Verification
The hardest situations to create are those in which a stall overlaps other hazards. Examples are a load whose dependent also needs a second producer, a load into register 0, a load with write-enable low, and a load followed by a second load that the stalled instruction depends on. Random streams never line these up on purpose. The stimulus therefore starts with a directed program that places each of them deliberately, then runs a long random program over only four registers, so that producer and consumer fields collide almost every cycle. A behavioural model keeps a queue of what entered execute and predicts every output on every cycle. It holds the decode instruction while a stall is expected, just as a real pipeline would.

// File: rtl/hz_pkg.sv
// Shared constants and types for the hazard unit.
// Assumes a 32-entry register file (5-bit indices) and two forwarding sources.
package hz_pkg;
    localparam int REG_AW    = 5;  // register index width
    localparam int FWD_DEPTH = 2;  // producer stages after execute (memory, write-back)
    localparam int SEL_W     = 2;  // operand-select code width

    typedef enum logic [SEL_W-1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    // Destination part of an instruction, all that later stages need.
    typedef struct packed {
        logic [REG_AW-1:0] rd;
        logic              wen;
    } dst_t;

    // Control fields held in the execute stage.
    typedef struct packed {
        logic [REG_AW-1:0] rs1;
        logic [REG_AW-1:0] rs2;
        dst_t              dst;
        logic              load;
    } ex_ctl_t;

    localparam ex_ctl_t EX_NOP  = '0;
    localparam dst_t    DST_NOP = '0;
endpackage

// File: rtl/hz_stage_regs.sv
// Control registers that shadow the execute, memory and write-back stages.
// Assumes the caller holds the decode fields during a stall; on bubble the
// execute entry becomes a no-op while older entries keep advancing.
module hz_stage_regs
    import hz_pkg::*;
#(
    parameter int DEPTH = FWD_DEPTH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bubble,
    input  ex_ctl_t               id_in,
    output ex_ctl_t               ex_q,
    output dst_t [DEPTH-1:0]      dst_q
);
    // Execute stage: take the decode fields, or a no-op on bubble.
    always_ff @(posedge clk) begin
        if (!rst_n)      ex_q <= EX_NOP;
        else if (bubble) ex_q <= EX_NOP;
        else             ex_q <= id_in;
    end

    // Producer chain: index 0 is the memory stage, higher indices are older.
    for (genvar i = 0; i < DEPTH; i++) begin : g_chain
        if (i == 0) begin : g_head
            // Memory stage takes the destination leaving execute.
            always_ff @(posedge clk) begin
                if (!rst_n) dst_q[i] <= DST_NOP;
                else        dst_q[i] <= ex_q.dst;
            end
        end else begin : g_tail
            // Older stage takes the entry from the stage before it.
            always_ff @(posedge clk) begin
                if (!rst_n) dst_q[i] <= DST_NOP;
                else        dst_q[i] <= dst_q[i-1];
            end
        end
    end
endmodule

// File: rtl/hz_fwd_pick.sv
// Operand-select for one execute input. Scans producers from oldest to
// youngest so the youngest match overrides. Register 0 and non-writing
// producers never match.
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int DEPTH = FWD_DEPTH
) (
    input  logic [REG_AW-1:0]     src,
    input  dst_t [DEPTH-1:0]      prod,
    output logic [SEL_W-1:0]      sel
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    // Priority scan: later (younger) hits overwrite earlier (older) ones.
    always_comb begin
        sel = SEL_RF;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (prod[i].wen && (prod[i].rd != ZERO_REG) && (prod[i].rd == src))
                sel = SEL_W'(DEPTH - i);
        end
    end
endmodule

// File: rtl/hz_load_interlock.sv
// Load-use detector. Raises stall when the execute instruction is a writing
// load whose nonzero destination is a source of the decode instruction.
module hz_load_interlock
    import hz_pkg::*;
(
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  ex_ctl_t           ex_in,
    output logic              stall
);
    logic producer_live;
    logic src_hit;

    // Only a real, writing load into a nonzero register can block.
    always_comb producer_live = ex_in.load && ex_in.dst.wen && (ex_in.dst.rd != '0);

    // Either decode source reading that register forces the stall.
    always_comb src_hit = (id_rs1 == ex_in.dst.rd) || (id_rs2 == ex_in.dst.rd);

    // Final stall decision.
    always_comb stall = producer_live && src_hit;
endmodule

// File: rtl/pipe_hazard_unit.sv
// Forwarding and load-use interlock for a five-stage in-order pipeline.
// Tracks decode fields through shadow stage registers, produces the two
// execute operand selects and a one-cycle stall/bubble for load-use.
// Assumes the pipeline holds the decode inputs stable while stall is high.
module pipe_hazard_unit
    import hz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [REG_AW-1:0] id_rd,
    input  logic              id_wen,
    input  logic              id_load,
    output logic              stall,
    output logic              bubble,
    output logic [SEL_W-1:0]  fwd_a,
    output logic [SEL_W-1:0]  fwd_b
);
    localparam int NOPS = 2;

    ex_ctl_t                  id_ctl;
    ex_ctl_t                  ex_c;
    dst_t [FWD_DEPTH-1:0]     prod_c;
    logic [REG_AW-1:0]        op_src [NOPS];
    logic [SEL_W-1:0]         op_sel [NOPS];
    logic                     stall_w;

    // Pack decode fields into the stage record.
    always_comb begin
        id_ctl.rs1     = id_rs1;
        id_ctl.rs2     = id_rs2;
        id_ctl.dst.rd  = id_rd;
        id_ctl.dst.wen = id_wen;
        id_ctl.load    = id_load;
    end

    hz_stage_regs #(.DEPTH(FWD_DEPTH)) u_stages (
        .clk    (clk),
        .rst_n  (rst_n),
        .bubble (stall_w),
        .id_in  (id_ctl),
        .ex_q   (ex_c),
        .dst_q  (prod_c)
    );

    hz_load_interlock u_lock (
        .id_rs1 (id_rs1),
        .id_rs2 (id_rs2),
        .ex_in  (ex_c),
        .stall  (stall_w)
    );

    // Route execute sources to one selector per operand.
    always_comb begin
        op_src[0] = ex_c.rs1;
        op_src[1] = ex_c.rs2;
    end

    for (genvar k = 0; k < NOPS; k++) begin : g_op
        hz_fwd_pick #(.DEPTH(FWD_DEPTH)) u_pick (
            .src  (op_src[k]),
            .prod (prod_c),
            .sel  (op_sel[k])
        );
    end

    // Drive outputs; the stall also turns the next execute entry into a no-op.
    always_comb begin
        stall  = stall_w;
        bubble = stall_w;
        fwd_a  = op_sel[0];
        fwd_b  = op_sel[1];
    end
endmodule

// File: rtl/hz_checker.sv
// Property checker bound to pipe_hazard_unit. Observes the ports and the
// shadow stage registers; assumes decode inputs are held during a stall.
module hz_checker
    import hz_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [REG_AW-1:0]     id_rs1,
    input logic                  stall,
    input logic                  bubble,
    input logic [SEL_W-1:0]      fwd_a,
    input logic [SEL_W-1:0]      fwd_b,
    input ex_ctl_t               ex_c,
    input dst_t [FWD_DEPTH-1:0]  prod_c
);
    AST_SEL_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'b11) && (fwd_b != 2'b11)); // R2

    AST_YOUNGEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_c[0].wen && prod_c[1].wen && prod_c[0].rd != '0 &&
         prod_c[0].rd == prod_c[1].rd && ex_c.rs1 == prod_c[0].rd) |-> (fwd_a == 2'b10)); // R4

    AST_NO_STALL_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_c.dst.rd != '0)); // R6

    AST_NO_STALL_WEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_c.dst.wen) |-> !stall); // R7

    AST_LOAD_DATA_FROM_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && id_rs1 == ex_c.dst.rd) |-> ##2 (fwd_a == 2'b01)); // R9

    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall); // R10

    AST_BUBBLE_EMPTIES_EX: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (!ex_c.dst.wen && !ex_c.load)); // R10
endmodule

bind pipe_hazard_unit hz_checker u_hz_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .id_rs1 (id_rs1),
    .stall  (stall),
    .bubble (bubble),
    .fwd_a  (fwd_a),
    .fwd_b  (fwd_b),
    .ex_c   (ex_c),
    .prod_c (prod_c)
);

// File: tb/tb_pipe_hazard_unit.sv
`timescale 1ns/1ps
// Bench: behavioural queue model of the instructions entering execute,
// compared with the unit on every cycle.
module tb_pipe_hazard_unit;
    typedef struct {
        int rs1;
        int rs2;
        int rd;
        bit wen;
        bit load;
    } ins_t;

    localparam int NDIR  = 22;
    localparam int NPROG = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] id_rs1, id_rs2, id_rd;
    logic       id_wen, id_load;
    logic       stall, bubble;
    logic [1:0] fwd_a, fwd_b;

    int   nchk = 0;
    int   nerr = 0;
    bit   done = 0;
    ins_t prog [NPROG];
    ins_t hq [$];
    ins_t bub = '{0, 0, 0, 1'b0, 1'b0};

    pipe_hazard_unit dut (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd),
        .id_wen(id_wen), .id_load(id_load),
        .stall(stall), .bubble(bubble), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    always #2 clk = ~clk;

    task automatic chk(string tag, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic put(int i, int s1, int s2, int d, bit w, bit l);
        prog[i] = '{s1, s2, d, w, l};
    endtask

    task automatic drive(ins_t c);
        id_rs1  = 5'(c.rs1);
        id_rs2  = 5'(c.rs2);
        id_rd   = 5'(c.rd);
        id_wen  = c.wen;
        id_load = c.load;
    endtask

    function automatic bit hit(int src, ins_t p);
        return p.wen && p.rd != 0 && p.rd == src;
    endfunction

    function automatic int exp_sel(int src, ins_t m, ins_t w);
        if (hit(src, m)) return 2;
        if (hit(src, w)) return 1;
        return 0;
    endfunction

    function automatic string op_tag(int src, ins_t m, ins_t w);
        if (hit(src, m) && hit(src, w)) return "R4";
        if (hit(src, m)) return "R2";
        if (hit(src, w)) return w.load ? "R9" : "R3";
        if (src == 0 && ((m.rd == 0 && m.wen) || (w.rd == 0 && w.wen))) return "R6";
        if ((m.rd == src && !m.wen) || (w.rd == src && !w.wen)) return "R7";
        return "R5";
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int  pc;
        bit  prev_stall;
        // Directed program.
        put(0,  2, 3, 1, 1, 0);   // producer r1
        put(1,  1, 4, 6, 1, 0);   // r1 at distance 1 -> memory stage
        put(2,  5, 1, 7, 1, 0);   // r1 at distance 2 on B -> write-back
        put(3,  1, 8, 9, 1, 0);   // r1 at distance 3 -> register file
        put(4,  3, 3, 2, 1, 0);   // producer r2
        put(5,  3, 3, 2, 1, 0);   // producer r2 again
        put(6,  2, 2, 8, 1, 0);   // both stages hold r2 -> youngest
        put(7,  4, 4, 3, 1, 1);   // load r3
        put(8,  3, 3, 11, 1, 0);  // load-use on both sources
        put(9,  6, 6, 5, 1, 1);   // load r5
        put(10, 7, 7, 12, 1, 0);  // unrelated
        put(11, 5, 12, 13, 1, 0); // r5 two behind load, r12 one behind
        put(12, 1, 1, 0, 1, 0);   // writes r0
        put(13, 0, 0, 14, 1, 0);  // reads r0
        put(14, 1, 1, 0, 1, 1);   // load r0
        put(15, 0, 0, 15, 1, 0);  // reads r0 after load
        put(16, 2, 2, 9, 0, 0);   // r9 without write-enable
        put(17, 9, 9, 16, 1, 0);  // reads r9
        put(18, 2, 2, 10, 0, 1);  // load r10 without write-enable
        put(19, 10, 10, 17, 1, 0);// reads r10
        put(20, 2, 2, 18, 1, 1);  // load r18
        put(21, 9, 18, 19, 1, 1); // store-like use on B, itself a load
        // Random program over four registers.
        for (int i = NDIR; i < NPROG; i++)
            put(i, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 3)), $urandom_range(0, 7) != 0,
                $urandom_range(0, 2) == 0);

        repeat (3) hq.push_back(bub);
        put(0, 2, 3, 1, 1, 0);
        drive(prog[7]);               // a load in decode while in reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "stall after reset", int'(stall), 0);
        chk("R1", "bubble after reset", int'(bubble), 0);
        chk("R1", "fwd_a after reset", int'(fwd_a), 0);
        chk("R1", "fwd_b after reset", int'(fwd_b), 0);
        drive(prog[0]);
        rst_n = 1'b1;
        pc = 0;
        prev_stall = 0;

        while (pc < NPROG + 3) begin
            ins_t cur, ex, m, w;
            bit   es;
            string st;
            cur = (pc < NPROG) ? prog[pc] : bub;
            ex = hq[0];
            m  = hq[1];
            w  = hq[2];
            es = ex.load && hit(cur.rs1, ex) || ex.load && hit(cur.rs2, ex);
            if (prev_stall) st = "R10";
            else if (es) st = "R8";
            else if (ex.load && ex.wen && ex.rd == 0 && (cur.rs1 == 0 || cur.rs2 == 0)) st = "R6";
            else if (ex.load && !ex.wen && (cur.rs1 == ex.rd || cur.rs2 == ex.rd)) st = "R7";
            else st = "R8";
            chk(st, "stall", int'(stall), int'(es));
            chk(st, "bubble", int'(bubble), int'(es));
            chk(op_tag(ex.rs1, m, w), "fwd_a", int'(fwd_a), exp_sel(ex.rs1, m, w));
            chk({op_tag(ex.rs2, m, w), " R11"}, "fwd_b", int'(fwd_b), exp_sel(ex.rs2, m, w));
            @(posedge clk);
            #1;
            hq.push_front(es ? bub : cur);
            void'(hq.pop_back());
            if (!es) pc++;
            prev_stall = es;
            drive((pc < NPROG) ? prog[pc] : bub);
            @(negedge clk);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule